// File: doc/BRIEF.md
# Pseudo-random TLB replacement index generator

The block picks a TLB slot to overwrite when an entry has to be replaced. Each accepted request advances a 32-bit linear congruential generator. The upper half of the new state is reduced modulo the number of unwired slots, and the wired count is added to the remainder. The result therefore always lands in the range from the wired boundary to the last entry. Wired entries are never chosen.

The reduction runs on a restoring divider that produces one quotient bit per clock. The index is ready a fixed number of cycles after the request. While the divider works, `busy_o` is high and new requests are dropped. If the wired count is out of range, the last entry is returned in the next cycle and the divider is not started.

Top module: `tlb_rand_idx`

## Requirements
- R1: After reset the generator state is zero, and `valid_o` and `busy_o` are low.
- R2: Each accepted request replaces the state S with (S * 314159 + 1) mod 2^32.
- R3: The sample used for the index is bits [31:16] of the updated state.
- R4: With W = `wired_i` < N (N = TLB_ENTRIES), the index is (sample mod (N - W)) + W. W is taken at the request.
- R5: The state changes only on an accepted request. Idle cycles, however many, leave the index sequence unchanged.
- R6: For an in-range wired count, `busy_o` is high from the cycle after the request edge. `valid_o` pulses for exactly one cycle, 16 clock edges after the request edge, and `busy_o` falls in that same cycle.
- R7: A request made while `busy_o` is high is ignored. It does not advance the state, does not change the pending index and gives no extra `valid_o` pulse.
- R8: If `wired_i` >= N, `idx_o` = N-1 and `valid_o` is high in the cycle after the request edge. `busy_o` stays low, and the state still advances.
- R9: The boundary counts behave by R4. W = N-1 always gives index N-1, and W = 0 spans the full table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Index request strobe |
| wired_i | input | $clog2(TLB_ENTRIES)+1 | Number of wired (protected) low entries |
| idx_o | output | $clog2(TLB_ENTRIES) | Replacement index, meaningful while valid_o is high |
| valid_o | output | 1 | One-cycle pulse marking a new index |
| busy_o | output | 1 | Divider working; requests are ignored |

## Verification
A corrupted generator state shows up as a wrong index on the first request that follows. Because every later value is derived from it, the error also persists for the rest of the run. The bench therefore tracks its own copy of the generator through a sweep of all wired values, including the out-of-range ones. A divider step or counter fault shows either as a wrong remainder or as a latency other than 16 edges, and this is visible within the same request. Dropped-request handling is checked by comparing the indices after the dropped request against the model's sequence.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;
  localparam int unsigned LCG_W    = 32;
  localparam int unsigned SAMPLE_W = 16;
  localparam logic [LCG_W-1:0] LCG_MUL = 32'd314159;
  localparam logic [LCG_W-1:0] LCG_INC = 32'd1;
endpackage

// File: rtl/tlb_rand_lcg.sv
module tlb_rand_lcg
  import tlb_rand_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [LCG_W-1:0] state_o,
  output logic [LCG_W-1:0] next_o
);
  logic [LCG_W-1:0] state_q;

  assign next_o  = state_q * LCG_MUL + LCG_INC;
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (step_i) state_q <= next_o;
  end

  // odd multiplier plus odd increment flips the low bit on every step
  p_parity_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> state_q[0] != $past(state_q[0]));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> state_q == $past(state_q));
endmodule

// File: rtl/tlb_rand_urem.sv
module tlb_rand_urem #(
  parameter int unsigned DVD_W = 16,
  parameter int unsigned DVS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVS_W-1:0] rem_o
);
  localparam int unsigned CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] dvd_q;
  logic [DVS_W-1:0] dvs_q;
  logic [DVS_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DVS_W:0]   shifted, trial;
  logic             fits;
  logic [DVS_W-1:0] rem_n;

  always_comb begin
    shifted = {rem_q, dvd_q[DVD_W-1]};
    trial   = shifted - {1'b0, dvs_q};
    fits    = shifted >= {1'b0, dvs_q};
    rem_n   = fits ? trial[DVS_W-1:0] : shifted[DVS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        dvd_q  <= dividend_i;
        dvs_q  <= divisor_i;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(DVD_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        dvd_q <= dvd_q << 1;
        rem_q <= rem_n;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rem_o  = rem_q;

  p_rem_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q < dvs_q);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
  import tlb_rand_pkg::*;
#(
  parameter int unsigned TLB_ENTRIES = 16,
  localparam int unsigned IDX_W = $clog2(TLB_ENTRIES),
  localparam int unsigned WIR_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [WIR_W-1:0] wired_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             busy_o
);
  localparam logic [WIR_W-1:0] N_ENT = WIR_W'(TLB_ENTRIES);

  logic             accept, in_range, div_busy, div_done, clamp_q;
  logic [LCG_W-1:0] state, next_state;
  logic [WIR_W-1:0] wired_q, rem;
  logic [WIR_W-1:0] sum;

  assign accept   = req_i && !div_busy;
  assign in_range = wired_i < N_ENT;

  tlb_rand_lcg u_lcg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (accept),
    .state_o (state),
    .next_o  (next_state)
  );

  tlb_rand_urem #(.DVD_W(SAMPLE_W), .DVS_W(WIR_W)) u_urem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept && in_range),
    .dividend_i (next_state[LCG_W-1:LCG_W-SAMPLE_W]),
    .divisor_i  (N_ENT - wired_i),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .rem_o      (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wired_q <= '0;
      clamp_q <= 1'b0;
    end else begin
      clamp_q <= accept && !in_range;
      if (accept && in_range) wired_q <= wired_i;
    end
  end

  assign sum     = rem + wired_q;
  assign idx_o   = clamp_q ? IDX_W'(TLB_ENTRIES - 1) : sum[IDX_W-1:0];
  assign valid_o = div_done || clamp_q;
  assign busy_o  = div_busy;

  p_idx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_done |-> ({1'b0, idx_o} >= wired_q) && ({1'b0, idx_o} < N_ENT));

  p_clamp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && wired_i >= N_ENT) |=> valid_o && !busy_o);

  p_valid_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> valid_o);

  p_state_live_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o) |=> state == $past(state));
endmodule

// File: tb/tlb_rand_idx_tb.sv
module tlb_rand_idx_tb;
  localparam int N = 16;
  localparam int WW = $clog2(N) + 1;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [WW-1:0] wired = '0;
  logic [WW-2:0] idx;
  logic valid, busy;
  int checks = 0, errors = 0;
  logic [31:0] model = 32'd0;

  always #2 clk = ~clk;

  tlb_rand_idx #(.TLB_ENTRIES(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wired_i(wired),
    .idx_o(idx), .valid_o(valid), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // R2 R3 R4 R8: model step and expected index
  function automatic int next_exp(input int w);
    model = model * 32'd314159 + 32'd1;
    if (w >= N) return N - 1;
    return int'(model[31:16]) % (N - w) + w;
  endfunction

  task automatic do_req(input int w, input bit stray);
    int exp, lat;
    @(negedge clk);
    req = 1'b1; wired = WW'(w);
    exp = next_exp(w);
    @(negedge clk);
    req = 1'b0;
    lat = 0;
    if (w < N) chk(busy === 1'b1, "R6 busy after request", busy, 1);
    while (valid !== 1'b1 && lat < 40) begin
      if (stray && lat == 5) begin
        req = 1'b1; wired = WW'(N + 3);   // R7 request during busy
      end else req = 1'b0;
      @(negedge clk);
      lat++;
    end
    req = 1'b0;
    chk(lat == ((w < N) ? 16 : 0), w < N ? "R6 latency" : "R8 latency", lat, (w < N) ? 16 : 0);
    chk(int'(idx) == exp, w >= N ? "R8 clamp index" : (w == N-1 || w == 0) ? "R9 boundary index" : "R4 index", idx, exp);
    chk(busy === 1'b0, "R6 busy low at valid", busy, 0);
    @(negedge clk);
    chk(valid === 1'b0, stray ? "R7 no extra valid" : "R6 single pulse", valid, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(valid === 1'b0, "R1 valid in reset", valid, 0);
    chk(busy === 1'b0, "R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && busy === 1'b0, "R1 idle after reset", {valid, busy}, 0);
    // R1: first index derives from zero state (sample of state 1 is 0)
    do_req(0, 1'b0);
    // sweep every wired value, in and out of range
    for (int w = 0; w < (1 << WW); w++)
      for (int k = 0; k < 6; k++) do_req(w, 1'b0);
    // R5: long idle gap must not disturb the sequence
    repeat (37) @(negedge clk);
    for (int k = 0; k < 4; k++) do_req(3, 1'b0);
    // R7: stray request mid-computation is dropped
    do_req(2, 1'b1);
    do_req(5, 1'b1);
    for (int k = 0; k < 4; k++) do_req(1, 1'b0);
    // R8 back-to-back out-of-range requests
    do_req(N, 1'b0);
    do_req(N + 7, 1'b0);
    do_req(N - 1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule